// File: doc/BRIEF.md
# Indirect Register Access Port

This block decodes the host I/O window of a network controller. The window is 32 bytes long and is located by a base address from the configuration space. The low 16 bytes hold a read-only copy of the station address ROM. The upper half holds four ports:

- a pointer register;
- a data port for the control/status bank;
- a data port for the bus control bank;
- a reset port.

Software loads the pointer with a register index. A following access to either data port is then sent to that entry of the matching bank. The block drives the bank select, the index and the read or write strobe, and it returns the bank's read data to the host in the same cycle.

The window starts in narrow (16-bit) mode, with the four ports packed at 2-byte spacing. One 32-bit write to the control/status data port moves the block to wide (32-bit) mode, with the ports at 4-byte spacing. A read of the reset port of the active map does three things: it returns the block to narrow mode, it clears the pointer, and it raises a controller reset pulse long enough to cover 1 µs. The register banks sit outside this block.

Top module: `regwin_port`

## Requirements
- R1: After the hardware reset, `wide_mode` is 0, the pointer reads back as 0, `ctl_reset` is 0 and neither bank strobe is active.
- R2: An access reaches the window only when `io_addr[31:5]` equals `io_base[31:5]`. Bits 4:0 of `io_base` have no effect. An access outside the window gives no bank strobe and reads 0.
- R3: In narrow mode, 16-bit accesses use this map: 0x10 is the control/status data port, 0x12 the pointer, 0x14 the reset port and 0x16 the bus control data port. Read data is 16 bits with the upper 16 bits zero. Write data to a bank is `io_wdata[15:0]` zero-extended.
- R4: In wide mode, 32-bit accesses use this map: 0x10 is the control/status data port, 0x14 the pointer, 0x18 the reset port and 0x1C the bus control data port. Data is the full 32 bits.
- R5: An access whose width (`io_wide`) differs from the current mode gives no strobe, reads 0 and changes no state. The single exception is the one in R6.
- R6: In narrow mode, a 32-bit write to offset 0x10 sets `wide_mode` from the next cycle on. This write does not reach the bank.
- R7: A pointer write stores `io_wdata[PTR_W-1:0]`. A pointer read returns the stored value zero-extended. The pointer changes only through a pointer write or a reset port read.
- R8: An access to a data port drives `bank_idx` equal to the pointer. It also drives `bank_sel` (0 for control/status, 1 for bus control) and `bank_rd` or `bank_wr`, all in the same cycle as the host strobe. A read returns the selected bank's `*_rdata` combinationally.
- R9: Offsets 0x00 to 0x0F return station ROM bytes, little-endian, starting at the addressed byte: byte o sits in bits 7:0, byte o+1 in bits 15:8, and so on. Bytes past 0x0F read as 0. Writes to these offsets have no effect.
- R10: A read of the active reset port returns 0. From the next cycle, `ctl_reset` is high for exactly `RST_CYCLES` cycles, `wide_mode` is 0 and the pointer is 0. Nothing else lowers `wide_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| io_base | input | 32 | Window base from configuration; bits 4:0 ignored |
| io_addr | input | 32 | Host I/O address |
| io_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| io_rd | input | 1 | Host read strobe |
| io_wr | input | 1 | Host write strobe |
| io_wdata | input | 32 | Host write data |
| io_rdata | output | 32 | Host read data, valid in the cycle of `io_rd` |
| station_rom | input | 128 | Station address ROM copy, byte 0 in bits 7:0 |
| bank_sel | output | 1 | 0 = control/status bank, 1 = bus control bank |
| bank_idx | output | PTR_W | Register index taken from the pointer |
| bank_rd | output | 1 | Bank read strobe |
| bank_wr | output | 1 | Bank write strobe |
| bank_wdata | output | 32 | Write data for the bank |
| csr_rdata | input | 32 | Read data from the control/status bank |
| bcr_rdata | input | 32 | Read data from the bus control bank |
| wide_mode | output | 1 | Current access mode, 1 = 32-bit |
| ctl_reset | output | 1 | Controller reset pulse |

## Verification
A wrong mode bit shows up at the next data-port access. A port moved to the other map's offset gives a missing strobe or a zero read, visible in the same cycle. A pointer that drifts or fails to clear appears on `bank_idx` at the first data-port strobe after the fault. A reset pulse of the wrong length only shows once the whole pulse has ended, so the bench counts every cycle of `ctl_reset`. Mode leaks between the two maps are caught by probing each map's offsets with both access widths.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [2:0] {
    PORT_NONE,
    PORT_ROM,
    PORT_CSR,
    PORT_PTR,
    PORT_RST,
    PORT_BCR
  } port_e;

  localparam int WIN_LSB   = 5;
  localparam int ROM_BYTES = 16;

  // Window match: only address bits at and above WIN_LSB take part.
  function automatic logic win_hit(input logic [31:0] addr, input logic [31:0] base);
    return addr[31:WIN_LSB] == base[31:WIN_LSB];
  endfunction

  // Port kind for an in-window offset under the given map width.
  function automatic port_e port_of(input logic [4:0] off, input logic wide);
    if (off < 5'(ROM_BYTES)) return PORT_ROM;
    if (wide) begin
      case (off)
        5'h10:   return PORT_CSR;
        5'h14:   return PORT_PTR;
        5'h18:   return PORT_RST;
        5'h1C:   return PORT_BCR;
        default: return PORT_NONE;
      endcase
    end else begin
      case (off)
        5'h10:   return PORT_CSR;
        5'h12:   return PORT_PTR;
        5'h14:   return PORT_RST;
        5'h16:   return PORT_BCR;
        default: return PORT_NONE;
      endcase
    end
  endfunction

  // Little-endian slice of the station ROM starting at byte 'off'.
  function automatic logic [31:0] rom_slice(input logic [127:0] rom, input logic [4:0] off);
    return 32'(rom >> {off, 3'b000});
  endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
(
  input  logic [31:0] io_addr,
  input  logic [31:0] io_base,
  input  logic        io_wide,
  input  logic        io_wr,
  input  logic        wide_mode,
  output logic        hit,
  output port_e       port,
  output logic        mode_up
);

  logic [4:0] off;
  logic       width_ok;

  assign off      = io_addr[4:0];
  assign hit      = win_hit(io_addr, io_base);
  assign width_ok = (io_wide == wide_mode);

  always_comb begin
    port = PORT_NONE;
    if (hit && width_ok) port = port_of(off, wide_mode);
  end

  // The narrow-to-wide switch is the one access allowed across widths.
  assign mode_up = hit && io_wr && io_wide && !wide_mode && (off == 5'h10);

endmodule

// File: rtl/regwin_state.sv
module regwin_state #(
  parameter int PTR_W      = 8,
  parameter int RST_CYCLES = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_evt,
  input  logic             mode_up,
  input  logic             ptr_wr,
  input  logic [PTR_W-1:0] ptr_wdata,
  output logic             wide_mode,
  output logic [PTR_W-1:0] ptr,
  output logic             ctl_reset
);

  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_mode <= 1'b0;
      ptr       <= '0;
      cnt       <= '0;
    end else if (rst_evt) begin
      wide_mode <= 1'b0;
      ptr       <= '0;
      cnt       <= CNT_W'(RST_CYCLES);
    end else begin
      if (mode_up) wide_mode <= 1'b1;
      if (ptr_wr)  ptr <= ptr_wdata;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assign ctl_reset = (cnt != '0);

  AST_RST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (ctl_reset && !wide_mode && ptr == '0)); // R10
  AST_MODE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_up && !rst_evt) |=> wide_mode); // R6
  AST_MODE_DOWN_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wide_mode) |-> $past(rst_evt)); // R10
  AST_PTR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_wr && !rst_evt) |=> $stable(ptr)); // R7

endmodule

// File: rtl/regwin_rdmux.sv
module regwin_rdmux
  import regwin_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  port_e            port,
  input  logic             io_rd,
  input  logic             wide_mode,
  input  logic [4:0]       off,
  input  logic [127:0]     station_rom,
  input  logic [PTR_W-1:0] ptr,
  input  logic [31:0]      csr_rdata,
  input  logic [31:0]      bcr_rdata,
  output logic [31:0]      io_rdata
);

  logic [31:0] raw;

  always_comb begin
    case (port)
      PORT_ROM: raw = rom_slice(station_rom, off);
      PORT_PTR: raw = {{(32-PTR_W){1'b0}}, ptr};
      PORT_CSR: raw = csr_rdata;
      PORT_BCR: raw = bcr_rdata;
      default:  raw = '0;
    endcase
  end

  assign io_rdata = !io_rd ? 32'h0 : (wide_mode ? raw : {16'h0, raw[15:0]});

endmodule

// File: rtl/regwin_port.sv
module regwin_port
  import regwin_pkg::*;
#(
  parameter int PTR_W      = 8,
  parameter int RST_CYCLES = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      io_base,
  input  logic [31:0]      io_addr,
  input  logic             io_wide,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic [31:0]      io_wdata,
  output logic [31:0]      io_rdata,
  input  logic [127:0]     station_rom,
  output logic             bank_sel,
  output logic [PTR_W-1:0] bank_idx,
  output logic             bank_rd,
  output logic             bank_wr,
  output logic [31:0]      bank_wdata,
  input  logic [31:0]      csr_rdata,
  input  logic [31:0]      bcr_rdata,
  output logic             wide_mode,
  output logic             ctl_reset
);

  logic             hit;
  port_e            port;
  logic             mode_up;
  logic             rst_evt;
  logic             ptr_wr;
  logic             data_port;
  logic [PTR_W-1:0] ptr;

  regwin_decode u_decode (
    .io_addr   (io_addr),
    .io_base   (io_base),
    .io_wide   (io_wide),
    .io_wr     (io_wr),
    .wide_mode (wide_mode),
    .hit       (hit),
    .port      (port),
    .mode_up   (mode_up)
  );

  assign rst_evt   = io_rd && (port == PORT_RST);
  assign ptr_wr    = io_wr && (port == PORT_PTR);
  assign data_port = (port == PORT_CSR) || (port == PORT_BCR);

  regwin_state #(.PTR_W(PTR_W), .RST_CYCLES(RST_CYCLES)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_evt   (rst_evt),
    .mode_up   (mode_up),
    .ptr_wr    (ptr_wr),
    .ptr_wdata (io_wdata[PTR_W-1:0]),
    .wide_mode (wide_mode),
    .ptr       (ptr),
    .ctl_reset (ctl_reset)
  );

  regwin_rdmux #(.PTR_W(PTR_W)) u_rdmux (
    .port        (port),
    .io_rd       (io_rd),
    .wide_mode   (wide_mode),
    .off         (io_addr[4:0]),
    .station_rom (station_rom),
    .ptr         (ptr),
    .csr_rdata   (csr_rdata),
    .bcr_rdata   (bcr_rdata),
    .io_rdata    (io_rdata)
  );

  assign bank_sel   = (port == PORT_BCR);
  assign bank_idx   = ptr;
  assign bank_rd    = io_rd && data_port;
  assign bank_wr    = io_wr && data_port;
  assign bank_wdata = wide_mode ? io_wdata : {16'h0, io_wdata[15:0]};

  AST_NO_STROBE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> !(bank_rd || bank_wr)); // R2
  AST_WIDTH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_rd || bank_wr) |-> (io_wide == wide_mode)); // R5
  AST_SWITCH_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mode_up |-> !bank_wr); // R6
  AST_STROBE_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_rd |-> io_rd) and (bank_wr |-> io_wr)); // R8

endmodule

// File: tb/regwin_port_bench.sv
module regwin_port_bench;

  localparam int PTR_W      = 8;
  localparam int RST_CYCLES = 200;
  localparam logic [31:0] BASE = 32'h0000_C000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [31:0]      io_base;
  logic [31:0]      io_addr = '0;
  logic             io_wide = 1'b0;
  logic             io_rd = 1'b0;
  logic             io_wr = 1'b0;
  logic [31:0]      io_wdata = '0;
  logic [31:0]      io_rdata;
  logic [127:0]     station_rom;
  logic             bank_sel;
  logic [PTR_W-1:0] bank_idx;
  logic             bank_rd;
  logic             bank_wr;
  logic [31:0]      bank_wdata;
  logic [31:0]      csr_rdata;
  logic [31:0]      bcr_rdata;
  logic             wide_mode;
  logic             ctl_reset;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] c_rdata;
  logic        c_rd, c_wr, c_sel;
  logic [PTR_W-1:0] c_idx;
  logic [31:0] c_wdata;

  always #2.5 clk = ~clk;

  // The bench plays both register banks: data tagged by bank and index.
  assign csr_rdata = 32'hCA5E_0000 | 32'(bank_idx);
  assign bcr_rdata = 32'hB0C0_0000 | 32'(bank_idx);

  initial begin
    for (int i = 0; i < 16; i++) station_rom[i*8 +: 8] = 8'(8'h50 + i*3);
    io_base = BASE | 32'h1F; // low bits must not matter (R2)
  end

  regwin_port #(.PTR_W(PTR_W), .RST_CYCLES(RST_CYCLES)) u_regwin_port (
    .clk(clk), .rst_n(rst_n), .io_base(io_base), .io_addr(io_addr),
    .io_wide(io_wide), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .station_rom(station_rom), .bank_sel(bank_sel),
    .bank_idx(bank_idx), .bank_rd(bank_rd), .bank_wr(bank_wr),
    .bank_wdata(bank_wdata), .csr_rdata(csr_rdata), .bcr_rdata(bcr_rdata),
    .wide_mode(wide_mode), .ctl_reset(ctl_reset)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rom_bytes(input int off, input int n);
    logic [31:0] v = '0;
    for (int k = 0; k < n; k++)
      if (off + k < 16) v[k*8 +: 8] = station_rom[(off+k)*8 +: 8];
    return v;
  endfunction

  // One host access: drive at a falling edge, capture the combinational
  // response, then release; registered effects are visible on return.
  task automatic xfer(input logic [4:0] off, input bit w, input bit r, input bit wr,
                      input logic [31:0] d, input logic [31:0] base = BASE);
    @(negedge clk);
    io_addr = base | 32'(off); io_wide = w; io_rd = r; io_wr = wr; io_wdata = d;
    #1;
    c_rdata = io_rdata; c_rd = bank_rd; c_wr = bank_wr; c_sel = bank_sel;
    c_idx = bank_idx; c_wdata = bank_wdata;
    @(negedge clk);
    io_rd = 1'b0; io_wr = 1'b0;
  endtask

  task automatic t_reset_state;
    chk(wide_mode == 1'b0, "R1", 32'(wide_mode), 0);
    chk(ctl_reset == 1'b0, "R1", 32'(ctl_reset), 0);
    chk(!bank_rd && !bank_wr, "R1", {30'h0, bank_rd, bank_wr}, 0);
    xfer(5'h12, 0, 1, 0, 0);
    chk(c_rdata == 0, "R1 pointer", c_rdata, 0);
  endtask

  task automatic t_rom;
    xfer(5'h00, 0, 1, 0, 0);
    chk(c_rdata == rom_bytes(0, 2), "R9 off0", c_rdata, rom_bytes(0, 2));
    xfer(5'h05, 0, 1, 0, 0);
    chk(c_rdata == rom_bytes(5, 2), "R9 off5", c_rdata, rom_bytes(5, 2));
    xfer(5'h04, 0, 0, 1, 32'hFFFF);
    chk(!c_wr, "R9 write", 32'(c_wr), 0);
    xfer(5'h04, 0, 1, 0, 0);
    chk(c_rdata == rom_bytes(4, 2), "R9 after write", c_rdata, rom_bytes(4, 2));
    xfer(5'h00, 1, 1, 0, 0);
    chk(c_rdata == 0, "R5 wide ROM in narrow", c_rdata, 0);
  endtask

  task automatic t_narrow_ports;
    xfer(5'h12, 0, 0, 1, 32'h1234_0047);
    xfer(5'h12, 0, 1, 0, 0);
    chk(c_rdata == 32'h47, "R7 narrow ptr", c_rdata, 32'h47);
    xfer(5'h10, 0, 1, 0, 0);
    chk(c_rd && !c_sel && c_idx == 8'h47, "R8 csr strobe", {c_rd, c_sel, 22'h0, c_idx}, {2'b10, 22'h0, 8'h47});
    chk(c_rdata == 32'h0047, "R3 csr narrow data", c_rdata, 32'h0047);
    xfer(5'h16, 0, 0, 1, 32'hDEAD_BEEF);
    chk(c_wr && c_sel, "R8 bcr write", {c_wr, c_sel}, 2'b11);
    chk(c_wdata == 32'h0000_BEEF, "R3 narrow wdata", c_wdata, 32'h0000_BEEF);
    xfer(5'h16, 0, 1, 0, 0);
    chk(c_rdata == 32'h0047, "R3 bcr narrow data", c_rdata, 32'h0047);
    xfer(5'h18, 0, 1, 0, 0);
    chk(!c_rd && c_rdata == 0, "R3 unmapped narrow", c_rdata, 0);
    xfer(5'h10, 0, 1, 0, 0, 32'h0000_D000);
    chk(!c_rd && c_rdata == 0, "R2 outside window", c_rdata, 0);
    xfer(5'h12, 1, 0, 1, 32'h99);
    xfer(5'h12, 0, 1, 0, 0);
    chk(c_rdata == 32'h47, "R5 wide ptr write ignored", c_rdata, 32'h47);
  endtask

  task automatic t_switch;
    xfer(5'h10, 1, 0, 1, 32'h0);
    chk(!c_wr, "R6 no bank write", 32'(c_wr), 0);
    chk(wide_mode, "R6 wide mode", 32'(wide_mode), 1);
  endtask

  task automatic t_wide_ports;
    xfer(5'h14, 1, 0, 1, 32'hAAAA_005C);
    xfer(5'h14, 1, 1, 0, 0);
    chk(c_rdata == 32'h5C, "R4 wide ptr", c_rdata, 32'h5C);
    xfer(5'h10, 1, 1, 0, 0);
    chk(c_rd && !c_sel && c_rdata == 32'hCA5E_005C, "R4 csr wide", c_rdata, 32'hCA5E_005C);
    xfer(5'h1C, 1, 0, 1, 32'h8765_4321);
    chk(c_wr && c_sel && c_wdata == 32'h8765_4321, "R4 bcr wide write", c_wdata, 32'h8765_4321);
    xfer(5'h1C, 1, 1, 0, 0);
    chk(c_rdata == 32'hB0C0_005C, "R8 bcr wide read", c_rdata, 32'hB0C0_005C);
    xfer(5'h0E, 1, 1, 0, 0);
    chk(c_rdata == rom_bytes(14, 4), "R9 wide tail", c_rdata, rom_bytes(14, 4));
    xfer(5'h14, 0, 1, 0, 0);
    chk(ctl_reset == 0 && c_rdata == 0, "R5 narrow reset read in wide", c_rdata, 0);
    chk(wide_mode, "R5 mode kept", 32'(wide_mode), 1);
    xfer(5'h10, 0, 0, 1, 32'h1);
    chk(!c_wr, "R5 narrow write in wide", 32'(c_wr), 0);
  endtask

  task automatic t_port_reset;
    int n;
    xfer(5'h18, 1, 1, 0, 0);
    chk(c_rdata == 0, "R10 read value", c_rdata, 0);
    chk(!wide_mode, "R10 narrow after", 32'(wide_mode), 0);
    n = 0;
    while (ctl_reset && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == RST_CYCLES, "R10 pulse width", n, RST_CYCLES);
    xfer(5'h12, 0, 1, 0, 0);
    chk(c_rdata == 0, "R10 ptr cleared", c_rdata, 0);
    xfer(5'h14, 0, 1, 0, 0);
    chk(ctl_reset, "R10 narrow reset port", 32'(ctl_reset), 1);
    n = 0;
    while (ctl_reset && n < 1000) begin
      n++;
      @(negedge clk);
    end
    chk(n == RST_CYCLES, "R10 narrow pulse width", n, RST_CYCLES);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_rom();
    t_narrow_ports();
    t_switch();
    t_wide_ports();
    t_port_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule